// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Interface

This block connects an 8-bit multiplexed address/data host bus to the register set of a pattern tester. The host puts an address on the shared bus while the address strobe is high. The interface keeps that address when the strobe falls. In the second part of the cycle the host either reads a byte, with the block driving the bus, or writes a byte, with the block taking the value from the bus. The function behind each register is outside this block. Pattern, length and control values are held here and brought out as ports. Status and the two 32-bit counters are inputs that the block only reads.

A strap input, `style_sel`, chooses the bus timing style. When `style_sel` is 0, the bus uses separate active-low read and write strobes: `strb_a` is the read strobe and `strb_b` is the write strobe. When `style_sel` is 1, the bus uses an active-high data strobe on `strb_a` and a read/write level on `strb_b`, where high means read. All bus inputs are sampled on `clk`. A four-state machine tracks the cycle. IDLE goes to ADDR when the address strobe is high, to READ when a read strobe is seen, and to WRITE when a write strobe is seen, with that priority. ADDR returns to IDLE on the falling edge of the address strobe and latches the address. READ returns to IDLE when the read condition ends. WRITE returns to IDLE when the write condition ends and commits the byte.

Top module: `mux_bus_host_if`

## Requirements
- R1: After reset, `ad_oe` is 0, `ad_out` is 0, and `pattern_word`, `pat_len` and `ctrl_word` are all 0.
- R2: The latched address is the bus value from the last sample taken while `ale` was high. Whatever is on the bus in the same sample where `ale` is first seen low is not used as the address.
- R3: In style 0, a read starts when `strb_a` is low. `ad_oe` rises two clock edges after the strobe is applied, and `ad_out` then shows the addressed byte.
- R4: In style 0, `ad_oe` stays high while `strb_a` is low. It falls two clock edges after `strb_a` returns high.
- R5: In style 1, a read is `strb_a` high with `strb_b` high. `ad_oe` rises two edges after `strb_a` rises and falls two edges after `strb_a` falls.
- R6: In style 1, a write is `strb_a` high with `strb_b` low. In style 0, a write is `strb_b` low.
- R7: A write commits on the trailing edge of the write condition, two clock edges after the strobe ends. The byte stored is the last bus value sampled while the write was active. The target register does not change before that edge.
- R8: Index 0 to 3 is `pattern_word`, with index 0 holding bits 31:24. Index 4 is `pat_len`: writes keep the low 5 bits and reads return them zero-extended. Index 5 is `ctrl_word`. Index 6 reads `status_in`.
- R9: Index 8 to 11 reads `bit_count` and index 12 to 15 reads `err_count`, in both cases with the most significant byte at the lowest index.
- R10: Only the low 4 address bits select a register. An address with any of bits 7:4 set, and index 7, read as 0. Writes to those addresses and to indices 6 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_sel | input | 1 | Timing style strap: 0 = separate strobes, 1 = level plus data strobe |
| ale | input | 1 | Address latch strobe, active high |
| strb_a | input | 1 | Style 0: read strobe, active low. Style 1: data strobe, active high |
| strb_b | input | 1 | Style 0: write strobe, active low. Style 1: read/write level, high means read |
| ad_in | input | 8 | Bus value seen at the pins |
| ad_out | output | 8 | Read data to the bus drivers |
| ad_oe | output | 1 | Enable for the bus drivers |
| status_in | input | 8 | Status byte, read at index 6 |
| bit_count | input | 32 | Bit counter, read at indices 8 to 11 |
| err_count | input | 32 | Error counter, read at indices 12 to 15 |
| pattern_word | output | 32 | Pattern register |
| pat_len | output | 5 | Length register |
| ctrl_word | output | 8 | Control register |

## Verification
The assertions assume that the bus inputs are synchronous to `clk`. They also assume that the host does not overlap an address phase with a data strobe, and that in style 1 the read/write level is set no later than the data strobe. The bench drives every input on the falling clock edge. Each phase is held for several cycles, and the strobes are always returned to the idle levels of the selected style before the strap changes. In style 1 the bench sets R/W together with, or before, the data strobe and releases it only after the data strobe has fallen.

// File: rtl/mbh_pkg.sv
package mbh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE
    } bus_state_t;
endpackage

// File: rtl/mbh_sampler.sv
module mbh_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_sel,
    input  logic              ale,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic [DATA_W-1:0] ad_in,
    output logic              s_ale,
    output logic [DATA_W-1:0] s_ad,
    output logic [DATA_W-1:0] p_ad,
    output logic              rd_act,
    output logic              wr_act
);
    logic s_style, s_a, s_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_style <= 1'b0;
            s_ale   <= 1'b0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            s_ad    <= '0;
            p_ad    <= '0;
        end else begin
            s_style <= style_sel;
            s_ale   <= ale;
            s_a     <= strb_a;
            s_b     <= strb_b;
            s_ad    <= ad_in;
            p_ad    <= s_ad;
        end
    end

    // Decode the strobes for the strap-selected timing style
    always_comb begin
        if (s_style) begin
            rd_act = s_a & s_b;
            wr_act = s_a & ~s_b;
        end else begin
            rd_act = ~s_a;
            wr_act = ~s_b;
        end
    end
endmodule

// File: rtl/mbh_fsm.sv
module mbh_fsm
    import mbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_ale,
    input  logic rd_act,
    input  logic wr_act,
    output logic addr_load,
    output logic read_start,
    output logic wr_commit,
    output logic drive_en
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (s_ale)       state_nx = ST_ADDR;
                else if (rd_act) state_nx = ST_READ;
                else if (wr_act) state_nx = ST_WRITE;
            end
            ST_ADDR:  if (!s_ale)  state_nx = ST_IDLE;
            ST_READ:  if (!rd_act) state_nx = ST_IDLE;
            ST_WRITE: if (!wr_act) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        addr_load  = (state == ST_ADDR) && !s_ale;
        read_start = (state == ST_IDLE) && !s_ale && rd_act;
        wr_commit  = (state == ST_WRITE) && !wr_act;
        drive_en   = (state == ST_READ);
    end
endmodule

// File: rtl/mbh_regmap.sv
module mbh_regmap #(
    parameter int DATA_W    = 8,
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 5,
    parameter int MAP_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] status_in,
    input  logic [WORD_W-1:0] bit_count,
    input  logic [WORD_W-1:0] err_count,
    output logic [WORD_W-1:0] pattern_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic [DATA_W-1:0] rd_data_q
);
    localparam int NB       = WORD_W / DATA_W;
    localparam int IDX_W    = $clog2(MAP_DEPTH);
    localparam int PAT_BASE = 0;
    localparam int LEN_IDX  = NB;
    localparam int CTL_IDX  = NB + 1;
    localparam int STAT_IDX = NB + 2;
    localparam int BC_BASE  = MAP_DEPTH - 2 * NB;
    localparam int EC_BASE  = MAP_DEPTH - NB;

    logic             sel;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rd_mux;

    assign sel = (addr[DATA_W-1:IDX_W] == '0);
    assign idx = addr[IDX_W-1:0];

    // Pattern bytes, most significant byte at the lowest index
    for (genvar b = 0; b < NB; b++) begin : g_pat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pattern_q[(NB-1-b)*DATA_W +: DATA_W] <= '0;
            else if (wr_en && sel && idx == IDX_W'(PAT_BASE + b))
                pattern_q[(NB-1-b)*DATA_W +: DATA_W] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            ctl_q <= '0;
        end else if (wr_en && sel) begin
            if (idx == IDX_W'(LEN_IDX)) len_q <= wr_data[LEN_W-1:0];
            if (idx == IDX_W'(CTL_IDX)) ctl_q <= wr_data;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel) begin
            for (int b = 0; b < NB; b++) begin
                if (idx == IDX_W'(PAT_BASE + b)) rd_mux = pattern_q[(NB-1-b)*DATA_W +: DATA_W];
                if (idx == IDX_W'(BC_BASE + b))  rd_mux = bit_count[(NB-1-b)*DATA_W +: DATA_W];
                if (idx == IDX_W'(EC_BASE + b))  rd_mux = err_count[(NB-1-b)*DATA_W +: DATA_W];
            end
            if (idx == IDX_W'(LEN_IDX))  rd_mux = {{(DATA_W-LEN_W){1'b0}}, len_q};
            if (idx == IDX_W'(CTL_IDX))  rd_mux = ctl_q;
            if (idx == IDX_W'(STAT_IDX)) rd_mux = status_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data_q <= '0;
        else if (rd_load) rd_data_q <= rd_mux;
    end
endmodule

// File: rtl/mux_bus_host_if.sv
module mux_bus_host_if #(
    parameter int DATA_W    = 8,
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 5,
    parameter int MAP_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_sel,
    input  logic              ale,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] status_in,
    input  logic [WORD_W-1:0] bit_count,
    input  logic [WORD_W-1:0] err_count,
    output logic [WORD_W-1:0] pattern_word,
    output logic [LEN_W-1:0]  pat_len,
    output logic [DATA_W-1:0] ctrl_word
);
    logic              s_ale, rd_act, wr_act;
    logic [DATA_W-1:0] s_ad, p_ad, addr_q, wdata_q;
    logic              addr_load, read_start, wr_commit;

    mbh_sampler #(.DATA_W(DATA_W)) u_samp (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .ale(ale),
        .strb_a(strb_a), .strb_b(strb_b), .ad_in(ad_in),
        .s_ale(s_ale), .s_ad(s_ad), .p_ad(p_ad),
        .rd_act(rd_act), .wr_act(wr_act)
    );

    mbh_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .s_ale(s_ale), .rd_act(rd_act),
        .wr_act(wr_act), .addr_load(addr_load), .read_start(read_start),
        .wr_commit(wr_commit), .drive_en(ad_oe)
    );

    // Address from the last sample with ALE high; write data from the last active sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (addr_load) addr_q  <= p_ad;
            if (wr_act)    wdata_q <= s_ad;
        end
    end

    mbh_regmap #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .LEN_W(LEN_W), .MAP_DEPTH(MAP_DEPTH)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .wr_en(wr_commit),
        .wr_data(wdata_q), .rd_load(read_start), .status_in(status_in),
        .bit_count(bit_count), .err_count(err_count),
        .pattern_q(pattern_word), .len_q(pat_len), .ctl_q(ctrl_word),
        .rd_data_q(ad_out)
    );
endmodule

// File: rtl/mbh_chk.sv
module mbh_chk #(
    parameter int DATA_W = 8,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [DATA_W-1:0] addr_q,
    input logic              rd_act,
    input logic              wr_act,
    input logic              wr_commit,
    input logic [WORD_W-1:0] pattern_word
);
    assert_oe_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(rd_act));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !rd_act) |=> !ad_oe);

    assert_commit_trailing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(wr_act) && !wr_act));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && (addr_q >> IDX_W) != '0) |-> ad_out == '0);

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && (addr_q >> IDX_W) != '0) |=> $stable(pattern_word));
endmodule

bind mux_bus_host_if mbh_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W($clog2(MAP_DEPTH))) u_chk (
    .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .ad_out(ad_out), .addr_q(addr_q),
    .rd_act(rd_act), .wr_act(wr_act), .wr_commit(wr_commit),
    .pattern_word(pattern_word)
);

// File: tb/mux_bus_host_if_tb.sv
module mux_bus_host_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic clk = 1'b0, rst_n = 1'b0;
    logic style_sel = 1'b0, ale = 1'b0, strb_a = 1'b1, strb_b = 1'b1;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out, ctrl_word;
    logic        ad_oe;
    logic [4:0]  pat_len;
    logic [31:0] pattern_word;
    logic [7:0]  status_in = 8'h5A;
    logic [31:0] bit_count = 32'h1234_5678;
    logic [31:0] err_count = 32'h9ABC_DEF0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .ale(ale),
        .strb_a(strb_a), .strb_b(strb_b), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .status_in(status_in), .bit_count(bit_count),
        .err_count(err_count), .pattern_word(pattern_word),
        .pat_len(pat_len), .ctrl_word(ctrl_word)
    );

    // {req(4), style(1), write(1), addr(8), data(8), expected(8)}
    localparam logic [29:0] VEC [NVEC] = '{
        {4'd6, 1'b0, 1'b1, 8'h00, 8'hA1, 8'h00},  // R6 style 0 write
        {4'd6, 1'b0, 1'b1, 8'h01, 8'hB2, 8'h00},
        {4'd6, 1'b1, 1'b1, 8'h02, 8'hC3, 8'h00},  // R6 style 1 write
        {4'd6, 1'b1, 1'b1, 8'h03, 8'hD4, 8'h00},
        {4'd8, 1'b0, 1'b1, 8'h04, 8'hFF, 8'h00},
        {4'd8, 1'b1, 1'b1, 8'h05, 8'h3C, 8'h00},
        {4'd10, 1'b0, 1'b1, 8'h08, 8'h77, 8'h00}, // R10 read-only
        {4'd10, 1'b1, 1'b1, 8'h06, 8'h11, 8'h00},
        {4'd10, 1'b0, 1'b1, 8'h14, 8'h02, 8'h00}, // R10 upper bits set
        {4'd10, 1'b1, 1'b1, 8'h11, 8'h99, 8'h00},
        {4'd8, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA1},  // R8 reads
        {4'd8, 1'b1, 1'b0, 8'h01, 8'h00, 8'hB2},
        {4'd8, 1'b0, 1'b0, 8'h02, 8'h00, 8'hC3},
        {4'd8, 1'b1, 1'b0, 8'h03, 8'h00, 8'hD4},
        {4'd8, 1'b0, 1'b0, 8'h04, 8'h00, 8'h1F},
        {4'd8, 1'b1, 1'b0, 8'h05, 8'h00, 8'h3C},
        {4'd8, 1'b0, 1'b0, 8'h06, 8'h00, 8'h5A},
        {4'd10, 1'b1, 1'b0, 8'h07, 8'h00, 8'h00},
        {4'd9, 1'b0, 1'b0, 8'h08, 8'h00, 8'h12}, // R9 counters
        {4'd9, 1'b1, 1'b0, 8'h09, 8'h00, 8'h34},
        {4'd9, 1'b0, 1'b0, 8'h0A, 8'h00, 8'h56},
        {4'd9, 1'b1, 1'b0, 8'h0B, 8'h00, 8'h78},
        {4'd9, 1'b0, 1'b0, 8'h0C, 8'h00, 8'h9A},
        {4'd9, 1'b1, 1'b0, 8'h0F, 8'h00, 8'hF0},
        {4'd10, 1'b0, 1'b0, 8'h10, 8'h00, 8'h00},
        {4'd10, 1'b1, 1'b0, 8'h8C, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_style(input logic m);
        @(negedge clk);
        style_sel = m;
        strb_a = m ? 1'b0 : 1'b1;
        strb_b = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // R2: bus changes to junk in the same cycle ALE falls
    task automatic addr_phase(input logic [7:0] a);
        ale = 1'b1; ad_in = a;
        repeat (2) @(negedge clk);
        ale = 1'b0; ad_in = 8'hEE;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_cycle(input logic m, input logic w, input logic [7:0] a,
                             input logic [7:0] d, output logic [7:0] q, output logic oe);
        set_style(m);
        addr_phase(a);
        q = '0; oe = 1'b0;
        if (w) begin
            ad_in = d;
            if (m) begin strb_b = 1'b0; strb_a = 1'b1; end
            else strb_b = 1'b0;
            repeat (3) @(negedge clk);
            if (m) strb_a = 1'b0; else strb_b = 1'b1;
            repeat (3) @(negedge clk);
            strb_b = 1'b1;
        end else begin
            ad_in = 8'h00;
            if (m) strb_a = 1'b1; else strb_a = 1'b0;
            repeat (3) @(negedge clk);
            q = ad_out; oe = ad_oe;
            strb_a = m ? 1'b0 : 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic oe;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 oe", 32'(ad_oe), 32'h0);
        check("R1 out", 32'(ad_out), 32'h0);
        check("R1 regs", pattern_word ^ 32'(pat_len) ^ 32'(ctrl_word), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            bus_cycle(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], q, oe);
            if (!VEC[i][24]) begin
                // R3 / R5: driver enabled while reading
                check($sformatf("R%0d vec %0d data", VEC[i][29:26], i), 32'(q), 32'(VEC[i][7:0]));
                check($sformatf("R%0d vec %0d oe (R3/R5)", VEC[i][29:26], i), 32'(oe), 32'h1);
            end
        end
        check("R8 pattern_word port", pattern_word, 32'hA1B2_C3D4);
        check("R8 pat_len port", 32'(pat_len), 32'h1F);
        check("R10 ctrl_word untouched by unmapped writes", 32'(ctrl_word), 32'h3C);

        // R4: style 0 enable timing
        set_style(1'b0);
        addr_phase(8'h05);
        strb_a = 1'b0;
        @(negedge clk); check("R4 oe one edge after strobe", 32'(ad_oe), 32'h0);
        @(negedge clk); check("R3 oe two edges after strobe", 32'(ad_oe), 32'h1);
        check("R3 data", 32'(ad_out), 32'h3C);
        strb_a = 1'b1;
        @(negedge clk); check("R4 oe held one edge after release", 32'(ad_oe), 32'h1);
        @(negedge clk); check("R4 oe released", 32'(ad_oe), 32'h0);

        // R5: style 1 read ends on data strobe fall
        set_style(1'b1);
        addr_phase(8'h06);
        strb_a = 1'b1;
        repeat (2) @(negedge clk); check("R5 oe on", 32'(ad_oe), 32'h1);
        strb_a = 1'b0;
        @(negedge clk); check("R5 oe held", 32'(ad_oe), 32'h1);
        @(negedge clk); check("R5 oe off after DS fall", 32'(ad_oe), 32'h0);

        // R7: last sampled data commits at the trailing edge only
        set_style(1'b0);
        addr_phase(8'h02);
        ad_in = 8'h11; strb_b = 1'b0;
        repeat (3) @(negedge clk);
        ad_in = 8'h22;
        repeat (3) @(negedge clk);
        check("R7 no commit mid-strobe", 32'(pattern_word[15:8]), 32'hC3);
        strb_b = 1'b1;
        @(negedge clk); check("R7 no commit one edge after", 32'(pattern_word[15:8]), 32'hC3);
        @(negedge clk); check("R7 commit of last data", 32'(pattern_word[15:8]), 32'h22);
        check("R7 write enables no driver", 32'(ad_oe), 32'h0);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule